// File: doc/BRIEF.md
# Monotonic Security Level Access Guard

This block keeps the current protection level of an on-chip memory controller and rules on every memory or configuration operation that a command decoder presents to it. Each request carries a decoded operation class and, for a level change, the proposed new level value. One clock later the guard answers with a single-cycle allow or deny pulse. A deny pulse carries the offending operation class, so the responder upstream can pick the right error reply.

The level can only become stricter. A level-change request that would relax the level, keep it the same, or carry an unknown code is refused. The only way back to the open level is the strobe that marks the end of a full chip erase. A parameter decides whether a synchronous reset reloads the open level or leaves the stored level as it is, which models a non-volatile setting.

Top module: `sec_access_guard`

## Requirements
- R1: With RESET_RELOAD=1, a cycle with `rst` high clears `allow`, `deny` and `deny_op` and sets `level` to 8'hFF (open) on the next edge.
- R2: With RESET_RELOAD=0, reset clears the three response outputs but leaves `level` unchanged. The power-up value of `level` is 8'hFF.
- R3: Level codes are 8'hFF open, 8'hFE write-protected and 8'hFC read/write-protected, ranked from least to most strict in that order. A level-change request (op 6) whose `req_level` is stricter than `level` is allowed, and `level` takes the new value one edge after the request.
- R4: A level-change request with a `req_level` that is equal, less strict or not one of the three codes is denied, and `level` stays unchanged.
- R5: At 8'hFE, writes to memory (op 1), fuses (op 3) and boot configuration (op 5) and block erase are denied. Memory reads (op 0), fuse reads (op 2), boot configuration reads (op 4), identity reads (op 7) and level reads (op 11) are allowed.
- R6: At 8'hFC, memory and fuse reads and writes (ops 0 to 3) are denied. Boot configuration reads, identity reads and level reads are still allowed.
- R7: Block erase (op 8) is allowed only at 8'hFF. Full chip erase (op 9) and blank check (op 10) are allowed at every level.
- R8: An `erase_done` pulse sets `level` to 8'hFF on the next edge. It takes priority over a level change presented in the same cycle.
- R9: Every cycle with `req_valid` high produces exactly one of `allow` or `deny`, high for one cycle, one edge later. `deny_op` equals the request's op code while `deny` is high and is 0 otherwise. With no request, both pulses stay low.
- R10: Op codes 12 to 15 are undefined and are always denied. At 8'hFF, every defined op other than a refused level change is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Decoded operation class |
| req_level | input | 8 | Proposed new level for op 6 |
| erase_done | input | 1 | Full chip erase finished strobe |
| allow | output | 1 | Request granted pulse |
| deny | output | 1 | Request refused pulse |
| deny_op | output | 4 | Op class of the refused request |
| level | output | 8 | Current security level |

## Verification
The bench walks every op code at each of the three levels. A permission table that is wrong in any single cell shows up as a wrong pulse on that op. It tries to relax the level, to rewrite the current level and to load an unknown code. A comparison that is not strict, or a missing check on the code, would let the level drop or take a bad value. It raises `erase_done` together with a stricter level change, which catches a design with the wrong priority because the level would not return to open. It also resets a second instance built without reload; a design that clears the level on reset regardless of the parameter would lose the stored protection there.

// File: rtl/sec_guard_pkg.sv
package sec_guard_pkg;
  localparam int OP_W  = 4;
  localparam int LVL_W = 8;

  localparam logic [LVL_W-1:0] LVL_OPEN = 8'hFF;
  localparam logic [LVL_W-1:0] LVL_WP   = 8'hFE;
  localparam logic [LVL_W-1:0] LVL_RWP  = 8'hFC;

  typedef enum logic [OP_W-1:0] {
    OP_RD_MEM    = 4'd0,
    OP_WR_MEM    = 4'd1,
    OP_RD_FUSE   = 4'd2,
    OP_WR_FUSE   = 4'd3,
    OP_RD_BOOT   = 4'd4,
    OP_WR_BOOT   = 4'd5,
    OP_WR_SEC    = 4'd6,
    OP_RD_ID     = 4'd7,
    OP_ERASE_BLK = 4'd8,
    OP_ERASE_ALL = 4'd9,
    OP_BLANK     = 4'd10,
    OP_RD_SEC    = 4'd11
  } op_e;

  localparam int NUM_OPS = 1 << OP_W;

  // strictness rank: 0 open, 1 write-protected, 2 read/write-protected, 3 invalid
  function automatic logic [1:0] lvl_rank(input logic [LVL_W-1:0] v);
    case (v)
      LVL_OPEN: return 2'd0;
      LVL_WP:   return 2'd1;
      LVL_RWP:  return 2'd2;
      default:  return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/sec_level_reg.sv
module sec_level_reg
  import sec_guard_pkg::*;
#(
  parameter bit RESET_RELOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [LVL_W-1:0] set_val,
  input  logic             clear_en,
  output logic [LVL_W-1:0] lvl
);
  logic [LVL_W-1:0] lvl_q = LVL_OPEN;

  generate
    if (RESET_RELOAD) begin : g_reload
      always_ff @(posedge clk) begin
        if (rst)           lvl_q <= LVL_OPEN;
        else if (clear_en) lvl_q <= LVL_OPEN;
        else if (set_en)   lvl_q <= set_val;
      end
    end else begin : g_keep
      always_ff @(posedge clk) begin
        if (!rst) begin
          if (clear_en)    lvl_q <= LVL_OPEN;
          else if (set_en) lvl_q <= set_val;
        end
      end
    end
  endgenerate

  assign lvl = lvl_q;
endmodule

// File: rtl/sec_perm_matrix.sv
module sec_perm_matrix
  import sec_guard_pkg::*;
(
  input  logic [LVL_W-1:0] cur_lvl,
  input  logic [OP_W-1:0]  op,
  input  logic [LVL_W-1:0] new_lvl,
  output logic             grant,
  output logic             raise
);
  localparam logic [NUM_OPS-1:0] MASK_OPEN = 16'h0FBF;
  localparam logic [NUM_OPS-1:0] MASK_WP   = 16'h0E95;
  localparam logic [NUM_OPS-1:0] MASK_RWP  = 16'h0E90;

  logic [NUM_OPS-1:0] mask;
  logic [1:0]         cur_rank;
  logic [1:0]         new_rank;

  always_comb begin
    cur_rank = lvl_rank(cur_lvl);
    new_rank = lvl_rank(new_lvl);
    case (cur_rank)
      2'd0:    mask = MASK_OPEN;
      2'd1:    mask = MASK_WP;
      2'd2:    mask = MASK_RWP;
      default: mask = MASK_RWP;
    endcase
    raise = (op == OP_WR_SEC) && (new_rank != 2'd3) && (new_rank > cur_rank);
    grant = mask[op] | raise;
  end
endmodule

// File: rtl/sec_access_guard.sv
module sec_access_guard
  import sec_guard_pkg::*;
#(
  parameter bit RESET_RELOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [OP_W-1:0]  req_op,
  input  logic [LVL_W-1:0] req_level,
  input  logic             erase_done,
  output logic             allow,
  output logic             deny,
  output logic [OP_W-1:0]  deny_op,
  output logic [LVL_W-1:0] level
);
  logic grant;
  logic raise;

  sec_perm_matrix u_matrix (
    .cur_lvl (level),
    .op      (req_op),
    .new_lvl (req_level),
    .grant   (grant),
    .raise   (raise)
  );

  sec_level_reg #(.RESET_RELOAD(RESET_RELOAD)) u_level (
    .clk      (clk),
    .rst      (rst),
    .set_en   (req_valid && raise),
    .set_val  (req_level),
    .clear_en (erase_done),
    .lvl      (level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      allow   <= 1'b0;
      deny    <= 1'b0;
      deny_op <= '0;
    end else begin
      allow   <= req_valid && grant;
      deny    <= req_valid && !grant;
      deny_op <= (req_valid && !grant) ? req_op : '0;
    end
  end
endmodule

// File: rtl/sec_guard_chk.sv
module sec_guard_chk
  import sec_guard_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [OP_W-1:0]  req_op,
  input logic             erase_done,
  input logic             allow,
  input logic             deny,
  input logic [OP_W-1:0]  deny_op,
  input logic [LVL_W-1:0] level
);
  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (allow ^ deny));
  // R9
  quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!allow && !deny));
  // R9
  deny_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rst) |=> (!deny || deny_op == $past(req_op)));
  // R4
  monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    !erase_done |=> ((level == $past(level)) || (lvl_rank(level) > lvl_rank($past(level)))));
  // R8
  erase_open_chk: assert property (@(posedge clk) disable iff (rst)
    erase_done |=> (level == LVL_OPEN));
  // R7
  full_erase_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_ERASE_ALL) |=> allow);
  // R10
  undef_op_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op >= 4'd12) |=> deny);
endmodule

bind sec_access_guard sec_guard_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .erase_done (erase_done),
  .allow      (allow),
  .deny       (deny),
  .deny_op    (deny_op),
  .level      (level)
);

// File: tb/tb_sec_access_guard.sv
`timescale 1ns/1ps
module tb_sec_access_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = 4'd0;
  logic [7:0] req_level = 8'hFF;
  logic       erase_done = 1'b0;

  logic       a0, d0, a1, d1;
  logic [3:0] o0, o1;
  logic [7:0] l0, l1;

  int checks = 0;
  int errors = 0;

  logic [7:0] ml [2];
  logic       ea [2];
  logic       edn[2];
  logic [3:0] eo [2];

  always #4 clk = ~clk;

  sec_access_guard #(.RESET_RELOAD(1'b1)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_level(req_level), .erase_done(erase_done),
    .allow(a0), .deny(d0), .deny_op(o0), .level(l0));

  sec_access_guard #(.RESET_RELOAD(1'b0)) dut_keep (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_level(req_level), .erase_done(erase_done),
    .allow(a1), .deny(d1), .deny_op(o1), .level(l1));

  function automatic int strict(input logic [7:0] v);
    if (v == 8'hFF) return 0;
    if (v == 8'hFE) return 1;
    if (v == 8'hFC) return 2;
    return -1;
  endfunction

  function automatic bit decide(input logic [7:0] lv, input int op, input logic [7:0] nl);
    int s = strict(lv);
    if (op == 6) return (strict(nl) >= 0) && (strict(nl) > s);
    if (op == 9 || op == 10) return 1;
    if (op > 11) return 0;
    if (s == 0) return 1;
    if (op == 8) return 0;
    if (op == 4 || op == 7 || op == 11) return 1;
    if (s == 1) return (op == 0 || op == 2);
    return 0;
  endfunction

  task automatic compare(input string tag);
    logic [3:0] ao [2];
    logic       aa [2];
    logic       ad [2];
    logic [7:0] al [2];
    aa[0] = a0; ad[0] = d0; ao[0] = o0; al[0] = l0;
    aa[1] = a1; ad[1] = d1; ao[1] = o1; al[1] = l1;
    for (int i = 0; i < 2; i++) begin
      checks++;
      if (aa[i] !== ea[i] || ad[i] !== edn[i] || ao[i] !== eo[i] || al[i] !== ml[i]) begin
        errors++;
        $display("FAIL %s inst%0d actual allow=%b deny=%b op=%0d level=%h expected allow=%b deny=%b op=%0d level=%h",
                 tag, i, aa[i], ad[i], ao[i], al[i], ea[i], edn[i], eo[i], ml[i]);
      end
    end
  endtask

  task automatic step(input bit r, input bit v, input int op, input logic [7:0] nl,
                      input bit ed, input string tag);
    rst = r; req_valid = v; req_op = op[3:0]; req_level = nl; erase_done = ed;
    for (int i = 0; i < 2; i++) begin
      if (r) begin
        ea[i] = 0; edn[i] = 0; eo[i] = 0;
        if (i == 0) ml[i] = 8'hFF;
      end else begin
        bit g = decide(ml[i], op, nl);
        ea[i]  = v && g;
        edn[i] = v && !g;
        eo[i]  = (v && !g) ? op[3:0] : 4'd0;
        if (ed) ml[i] = 8'hFF;
        else if (v && g && op == 6) ml[i] = nl;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic sweep(input string tag);
    for (int o = 0; o < 16; o++) step(0, 1, o, ml[0], 0, tag);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ml[0] = 8'hFF; ml[1] = 8'hFF;
    @(negedge clk);
    step(1, 0, 0, 8'hFF, 0, "R1 reset");
    step(1, 0, 0, 8'hFF, 0, "R1 reset");
    step(0, 0, 0, 8'hFF, 0, "R9 idle");
    // open level: everything allowed but undefined ops and same-level write
    sweep("R10 open sweep");
    step(0, 1, 6, 8'h55, 0, "R4 unknown code");
    step(0, 1, 6, 8'hFF, 0, "R4 same level");
    step(0, 1, 6, 8'hFE, 0, "R3 raise to FE");
    step(0, 0, 0, 8'hFF, 0, "R9 idle after raise");
    sweep("R5 FE sweep");
    step(0, 1, 8, 8'hFF, 0, "R7 block erase at FE");
    step(0, 1, 6, 8'hFF, 0, "R4 relax from FE");
    step(0, 1, 6, 8'hFE, 0, "R4 rewrite FE");
    step(0, 1, 6, 8'hFC, 0, "R3 raise to FC");
    sweep("R6 FC sweep");
    step(0, 1, 9, 8'hFF, 0, "R7 full erase at FC");
    step(0, 1, 10, 8'hFF, 0, "R7 blank check at FC");
    step(0, 1, 6, 8'hFE, 0, "R4 relax from FC");
    step(0, 0, 0, 8'hFF, 1, "R8 erase done");
    step(0, 1, 8, 8'hFF, 0, "R7 block erase after reopen");
    step(0, 1, 6, 8'hFE, 0, "R3 raise open to FE");
    step(0, 1, 6, 8'hFC, 1, "R8 erase wins over raise");
    step(0, 1, 6, 8'hFC, 0, "R3 raise open to FC");
    step(1, 0, 0, 8'hFF, 0, "R1 R2 reset with FC stored");
    step(0, 1, 0, 8'hFF, 0, "R2 read after reset");
    step(0, 1, 15, 8'hFF, 0, "R10 undefined op");
    step(0, 0, 0, 8'hFF, 1, "R8 erase done keep");
    step(0, 0, 0, 8'hFF, 0, "R9 final idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule